// File: doc/BRIEF.md
# Flash Write-Buffer Sequencer

This block runs the buffered-programming path of a parallel flash bank. A host arms it with the write-to-buffer command and gives a word count. It then sends that many data words plus one, and finally a confirm code. The data words land in a staging buffer that covers one aligned window of the array. The first data word fixes which window that is. The buffer is filled with the array's current contents of the window before any host data is merged in, so words the host does not touch keep their old values.

The array is only changed on a valid confirm. The whole window is then copied back in one sequential burst, one word per cycle. A write outside the window, a write while the bank is write-protected, or a wrong confirm code throws the staged data away, and no array write takes place. The program-error flag is sticky. The host polls the status ready bit, which reads 0 while the block is filling the buffer from the array or copying it back. Array timing is left to the memory behind the burst port, which returns read data one cycle after a read request.

Top module: `wbuf_sequencer`

## Requirements
- R1: A write of code 0xE8 (low 8 data bits) while idle starts a buffered sequence, selects status for reads (`rd_status`=1) and leaves status bit 7 set.
- R2: The write after 0xE8 is the count. Only its low DEV_BYTES*8 bits are kept. A kept count of N accepts exactly N+1 data writes, after which the next write is taken as the confirm.
- R3: The first data write of a sequence sets the window base to its word address with the low log2(buffer words) bits cleared. It raises `buf_active` and fills the whole buffer from the array words of that window in ascending order before storing its own data.
- R4: A data write whose word address lies outside the open window is dropped and sets status bit 4 (0x10). Bit 4 stays set until a 0x50 command in idle.
- R5: A confirm of 0xD0 with status bit 4 clear writes every buffer word to the array, in ascending address order from the window base, one word per cycle. The block then returns to idle with `rd_status`=1, status 0x80 and `buf_active`=0.
- R6: A confirm of any other code, or any confirm while status bit 4 is set, discards the buffer. The array is not written, `rd_status` goes to 0 and `buf_active` goes to 0.
- R7: The buffer covers (256 bytes if BANK_BYTES is 1, else 2048 bytes) times BANK_BYTES/DEV_BYTES. With the defaults that is 2048 words of 16 bits, so a commit issues 2048 array writes.
- R8: While `wp` is high, a data write sets status bit 4 and stores nothing. A first data write under `wp` does not open a window.
- R9: Status bit 7 reads 0 while the buffer is being filled or committed. Writes arriving in that time are ignored.
- R10: After reset, status is 0x80, `rd_status` is 0, `buf_active` is 0 and no array access is made.
- R11: In idle, 0x50 clears status bit 4 and selects array reads, 0xFF selects array reads, and 0x70 selects status reads. Any other code leaves status and `rd_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command/data write strobe |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | BANK_BYTES*8 | Command code (low 8 bits), count or data word |
| wp | input | 1 | Write protect for the bank |
| status | output | 8 | Bit 7 ready, bit 4 program error |
| rd_status | output | 1 | 1: host reads return status, 0: array data |
| buf_active | output | 1 | Staging window is open |
| arr_rd_en | output | 1 | Array read request (data returns next cycle) |
| arr_rd_addr | output | AW | Array read word address |
| arr_rd_data | input | BANK_BYTES*8 | Array read data |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_addr | output | AW | Array write word address |
| arr_wr_data | output | BANK_BYTES*8 | Array write data |

## Verification
The bench builds a full image of each 2048-word window and requires the commit burst to match it word for word. A design that skipped the fill, or stored the first data word before the fill, would copy back stale or clobbered neighbours. The count is sent with junk in its upper byte, so a design that kept the whole count would take the confirm as data and never commit. Aborts are covered for an out-of-window write, a wrong confirm code, a confirm after a sticky error and a write-protected bank, and any array write after an abort is caught. A count of zero with the first write on the last word of a window checks both the alignment and the exit from the data phase after a single write.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_DATA,
        ST_LOAD,
        ST_CONFIRM,
        ST_COMMIT
    } seq_state_e;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_FILL,
        MV_DRAIN
    } mover_mode_e;

    typedef struct packed {
        logic ready;
        logic prog_err;
    } stat_t;

    localparam logic [7:0] OP_ARM     = 8'hE8;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_CLRSTAT = 8'h50;
    localparam logic [7:0] OP_READARR = 8'hFF;
    localparam logic [7:0] OP_STATUS  = 8'h70;

    localparam int STAT_READY  = 7;
    localparam int STAT_PGMERR = 4;

    localparam stat_t STAT_RESET = '{ready: 1'b1, prog_err: 1'b0};

    // buffer words: byte size per device class, times parallel devices, per bank word
    function automatic int buf_words(int bank_bytes, int dev_bytes);
        int per_dev;
        per_dev = (bank_bytes == 1) ? 256 : 2048;
        return (per_dev * (bank_bytes / dev_bytes)) / bank_bytes;
    endfunction

    function automatic logic [7:0] pack_status(stat_t s, logic busy);
        logic [7:0] v;
        v = 8'h00;
        v[STAT_READY]  = s.ready & ~busy;
        v[STAT_PGMERR] = s.prog_err;
        return v;
    endfunction

endpackage

// File: rtl/wbuf_window.sv
module wbuf_window #(
    parameter int AW    = 13,
    parameter int IDX_W = 11,
    parameter int TAG_W = AW - IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open,
    input  logic             close,
    input  logic [AW-1:0]    addr,
    output logic             active,
    output logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic             active_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            tag_q    <= '0;
        end else if (close) begin
            active_q <= 1'b0;
        end else if (open) begin
            active_q <= 1'b1;
            tag_q    <= addr[AW-1:IDX_W];
        end
    end

    assign active = active_q;
    assign tag    = tag_q;
    assign hit    = (addr[AW-1:IDX_W] == tag_q);
    assign idx    = addr[IDX_W-1:0];

endmodule

// File: rtl/wbuf_stage.sv
module wbuf_stage #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 2048,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[widx] <= wdata;
        end
    end

    assign rdata = cells_q[ridx];

endmodule

// File: rtl/wbuf_mover.sv
module wbuf_mover
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_fill,
    input  logic             go_drain,
    output logic             rd_en,
    output logic             wr_en,
    output logic [IDX_W-1:0] idx,
    output logic             cap_en,
    output logic [IDX_W-1:0] cap_idx,
    output logic             fill_done,
    output logic             drain_done
);
    localparam logic [IDX_W:0] CNT_END  = (IDX_W + 1)'(DEPTH);
    localparam logic [IDX_W:0] CNT_LAST = (IDX_W + 1)'(DEPTH - 1);

    mover_mode_e      mode_q;
    logic [IDX_W:0]   cnt_q;
    logic             cap_q;
    logic [IDX_W-1:0] cap_idx_q;

    always_comb begin
        idx        = cnt_q[IDX_W-1:0];
        rd_en      = (mode_q == MV_FILL) && (cnt_q != CNT_END);
        wr_en      = (mode_q == MV_DRAIN);
        fill_done  = (mode_q == MV_FILL) && (cnt_q == CNT_END) && !cap_q;
        drain_done = (mode_q == MV_DRAIN) && (cnt_q == CNT_LAST);
        cap_en     = cap_q;
        cap_idx    = cap_idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MV_IDLE;
            cnt_q     <= '0;
            cap_q     <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_q     <= rd_en;
            cap_idx_q <= idx;
            case (mode_q)
                MV_IDLE: begin
                    cnt_q <= '0;
                    if (go_fill) begin
                        mode_q <= MV_FILL;
                    end else if (go_drain) begin
                        mode_q <= MV_DRAIN;
                    end
                end
                MV_FILL: begin
                    if (rd_en) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (fill_done) begin
                        mode_q <= MV_IDLE;
                    end
                end
                MV_DRAIN: begin
                    if (drain_done) begin
                        mode_q <= MV_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: mode_q <= MV_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wbuf_sequencer.sv
module wbuf_sequencer
    import wbuf_pkg::*;
#(
    parameter int BANK_BYTES = 2,
    parameter int DEV_BYTES  = 1,
    parameter int AW         = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [BANK_BYTES*8-1:0] wr_data,
    input  logic                    wp,
    output logic [7:0]              status,
    output logic                    rd_status,
    output logic                    buf_active,
    output logic                    arr_rd_en,
    output logic [AW-1:0]           arr_rd_addr,
    input  logic [BANK_BYTES*8-1:0] arr_rd_data,
    output logic                    arr_wr_en,
    output logic [AW-1:0]           arr_wr_addr,
    output logic [BANK_BYTES*8-1:0] arr_wr_data
);
    localparam int WORD_W    = BANK_BYTES * 8;
    localparam int CNT_W     = DEV_BYTES * 8;
    localparam int BUF_WORDS = buf_words(BANK_BYTES, DEV_BYTES);
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int TAG_W     = AW - IDX_W;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    stat_t             stat_q;
    logic              rd_status_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic [WORD_W-1:0] pend_data_q;

    logic              busy, accept, last_word;
    logic [7:0]        cmd;
    logic              go_fill, go_drain, abort, data_store;
    logic              win_active, win_hit;
    logic [TAG_W-1:0]  win_tag;
    logic [IDX_W-1:0]  win_idx;
    logic              mv_rd_en, mv_wr_en, mv_cap_en, mv_fill_done, mv_drain_done;
    logic [IDX_W-1:0]  mv_idx, mv_cap_idx;
    logic              st_we;
    logic [IDX_W-1:0]  st_widx;
    logic [WORD_W-1:0] st_wdata, st_rdata;

    always_comb begin
        busy       = (state_q == ST_LOAD) || (state_q == ST_COMMIT);
        accept     = wr_en && !busy;
        cmd        = wr_data[7:0];
        last_word  = (cnt_q == '0);
        go_fill    = (state_q == ST_DATA) && accept && !wp && !win_active;
        data_store = (state_q == ST_DATA) && accept && !wp && win_active && win_hit;
        go_drain   = (state_q == ST_CONFIRM) && accept && (cmd == OP_CONFIRM) && !stat_q.prog_err;
        abort      = (state_q == ST_CONFIRM) && accept && !go_drain;
    end

    // staging write source: array fill, then the held first word, then host data
    always_comb begin
        st_we    = 1'b0;
        st_widx  = mv_cap_idx;
        st_wdata = arr_rd_data;
        if (mv_cap_en) begin
            st_we = 1'b1;
        end else if (mv_fill_done) begin
            st_we    = 1'b1;
            st_widx  = pend_idx_q;
            st_wdata = pend_data_q;
        end else if (data_store) begin
            st_we    = 1'b1;
            st_widx  = win_idx;
            st_wdata = wr_data;
        end
    end

    wbuf_window #(
        .AW    (AW),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_window (
        .clk    (clk),
        .rst    (rst),
        .open   (go_fill),
        .close  (abort | mv_drain_done),
        .addr   (wr_addr),
        .active (win_active),
        .tag    (win_tag),
        .hit    (win_hit),
        .idx    (win_idx)
    );

    wbuf_stage #(
        .WORD_W (WORD_W),
        .DEPTH  (BUF_WORDS),
        .IDX_W  (IDX_W)
    ) u_stage (
        .clk   (clk),
        .we    (st_we),
        .widx  (st_widx),
        .wdata (st_wdata),
        .ridx  (mv_idx),
        .rdata (st_rdata)
    );

    wbuf_mover #(
        .DEPTH (BUF_WORDS),
        .IDX_W (IDX_W)
    ) u_mover (
        .clk        (clk),
        .rst        (rst),
        .go_fill    (go_fill),
        .go_drain   (go_drain),
        .rd_en      (mv_rd_en),
        .wr_en      (mv_wr_en),
        .idx        (mv_idx),
        .cap_en     (mv_cap_en),
        .cap_idx    (mv_cap_idx),
        .fill_done  (mv_fill_done),
        .drain_done (mv_drain_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            stat_q      <= STAT_RESET;
            rd_status_q <= 1'b0;
            pend_idx_q  <= '0;
            pend_data_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        case (cmd)
                            OP_ARM: begin
                                state_q      <= ST_COUNT;
                                rd_status_q  <= 1'b1;
                                stat_q.ready <= 1'b1;
                            end
                            OP_CLRSTAT: begin
                                stat_q.prog_err <= 1'b0;
                                rd_status_q     <= 1'b0;
                            end
                            OP_READARR: rd_status_q <= 1'b0;
                            OP_STATUS:  rd_status_q <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_COUNT: begin
                    if (accept) begin
                        cnt_q   <= wr_data[CNT_W-1:0];
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (go_fill) begin
                        pend_idx_q  <= win_idx;
                        pend_data_q <= wr_data;
                        state_q     <= ST_LOAD;
                    end else if (accept) begin
                        if (wp || !win_hit) begin
                            stat_q.prog_err <= 1'b1;
                        end
                        if (last_word) begin
                            state_q <= ST_CONFIRM;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (mv_fill_done) begin
                        if (last_word) begin
                            state_q <= ST_CONFIRM;
                        end else begin
                            cnt_q   <= cnt_q - 1'b1;
                            state_q <= ST_DATA;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (go_drain) begin
                        state_q <= ST_COMMIT;
                    end else if (abort) begin
                        state_q     <= ST_IDLE;
                        rd_status_q <= 1'b0;
                    end
                end
                ST_COMMIT: begin
                    if (mv_drain_done) begin
                        state_q     <= ST_IDLE;
                        rd_status_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign status      = pack_status(stat_q, busy);
    assign rd_status   = rd_status_q;
    assign buf_active  = win_active;
    assign arr_rd_en   = mv_rd_en;
    assign arr_rd_addr = {win_tag, mv_idx};
    assign arr_wr_en   = mv_wr_en;
    assign arr_wr_addr = {win_tag, mv_idx};
    assign arr_wr_data = st_rdata;

endmodule

// File: rtl/wbuf_sequencer_chk.sv
module wbuf_sequencer_chk #(
    parameter int BANK_BYTES = 2,
    parameter int AW         = 13
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [BANK_BYTES*8-1:0] wr_data,
    input logic [7:0]              status,
    input logic                    rd_status,
    input logic                    buf_active,
    input logic                    arr_rd_en,
    input logic                    arr_wr_en,
    input logic [AW-1:0]           arr_wr_addr
);
    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (status == 8'h80) && !rd_status && !buf_active && !arr_rd_en && !arr_wr_en);

    // R9
    busy_drain_chk: assert property (@(posedge clk) disable iff (rst)
        arr_wr_en |-> !status[7]);

    // R9
    busy_fill_chk: assert property (@(posedge clk) disable iff (rst)
        arr_rd_en |-> !status[7]);

    // R3
    fill_window_chk: assert property (@(posedge clk) disable iff (rst)
        arr_rd_en |-> buf_active);

    // R5
    drain_order_chk: assert property (@(posedge clk) disable iff (rst)
        arr_wr_en && $past(arr_wr_en) |-> arr_wr_addr == AW'($past(arr_wr_addr) + 1'b1));

    // R6
    discard_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(buf_active) && !$past(arr_wr_en) |-> !arr_wr_en);

    // R4
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        $past(status[4]) && !($past(wr_en) && $past(wr_data[7:0]) == 8'h50) |-> status[4]);

    // R5
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(arr_rd_en && arr_wr_en));

endmodule

bind wbuf_sequencer wbuf_sequencer_chk #(
    .BANK_BYTES (BANK_BYTES),
    .AW         (AW)
) u_wbuf_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .status      (status),
    .rd_status   (rd_status),
    .buf_active  (buf_active),
    .arr_rd_en   (arr_rd_en),
    .arr_wr_en   (arr_wr_en),
    .arr_wr_addr (arr_wr_addr)
);

// File: tb/tb_wbuf_sequencer.sv
module tb_wbuf_sequencer;
    localparam int AW   = 13;
    localparam int WW   = 16;
    localparam int BUFW = 2048;
    localparam int MEMW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic          wp = 1'b0;
    logic [7:0]    status;
    logic          rd_status, buf_active;
    logic          arr_rd_en, arr_wr_en;
    logic [AW-1:0] arr_rd_addr, arr_wr_addr;
    logic [WW-1:0] arr_rd_data = '0;
    logic [WW-1:0] arr_wr_data;

    logic [WW-1:0] mem [MEMW];

    typedef struct packed {
        logic [AW-1:0] a;
        logic [WW-1:0] d;
    } wr_item_t;
    wr_item_t exp_q[$];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wbuf_sequencer #(.BANK_BYTES(2), .DEV_BYTES(1), .AW(AW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wp(wp), .status(status), .rd_status(rd_status), .buf_active(buf_active),
        .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data)
    );

    // array model: one-cycle read latency
    always @(posedge clk) begin
        if (arr_rd_en) arr_rd_data <= mem[arr_rd_addr];
        if (arr_wr_en) mem[arr_wr_addr] <= arr_wr_data;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every array write must match the next expected item
    always @(negedge clk) begin
        if (!rst && arr_wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 array write with nothing staged", 32'(arr_wr_addr), 32'hFFFF_FFFF);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check(it.a == arr_wr_addr && it.d == arr_wr_data, "R5 commit word",
                      {3'b0, arr_wr_addr, arr_wr_data}, {3'b0, it.a, it.d});
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!status[7] && guard < 6000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // driver: builds the expected window image, pushes it, then runs the sequence
    task automatic buffered_write(input int first, input int n, input int step, input bit poke);
        int base;
        logic [WW-1:0] img [BUFW];
        base = first & ~(BUFW - 1);
        for (int j = 0; j < BUFW; j++) img[j] = mem[base + j];
        for (int k = 0; k < n; k++) img[first + k * step - base] = WW'(k * 4099 + 23130);
        for (int j = 0; j < BUFW; j++) exp_q.push_back({AW'(base + j), img[j]});
        wr('0, 16'h00E8);
        // upper byte is junk and must be dropped (R2)
        wr('0, {8'hA5, 8'(n - 1)});
        for (int k = 0; k < n; k++) begin
            wr(AW'(first + k * step), WW'(k * 4099 + 23130));
            if (k == 0) begin
                check(status[7] == 1'b0, "R9 ready low during fill", 32'(status), 32'h0);
                check(buf_active == 1'b1, "R3 window opened", 32'(buf_active), 32'h1);
            end
            wait_ready();
        end
        wr('0, 16'h00D0);
        check(status[7] == 1'b0, "R9 ready low during commit", 32'(status), 32'h0);
        // this write arrives during the commit and must be ignored (R9)
        if (poke) wr('0, 16'h0050);
        wait_ready();
        check(exp_q.size() == 0, "R2 R7 full window committed", 32'(exp_q.size()), 32'h0);
        check(rd_status == 1'b1, "R5 status selected after commit", 32'(rd_status), 32'h1);
        check(status == 8'h80, "R5 status after commit", 32'(status), 32'h80);
        check(buf_active == 1'b0, "R5 window closed", 32'(buf_active), 32'h0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < MEMW; i++) mem[i] = WW'(i * 37 + 11);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(status == 8'h80, "R10 status", 32'(status), 32'h80);
        check(rd_status == 1'b0, "R10 read mode", 32'(rd_status), 32'h0);
        check(buf_active == 1'b0, "R10 window", 32'(buf_active), 32'h0);

        // R11 idle commands
        wr('0, 16'h0070);
        check(rd_status == 1'b1, "R11 0x70 selects status", 32'(rd_status), 32'h1);
        wr('0, 16'h00FF);
        check(rd_status == 1'b0, "R11 0xFF selects array", 32'(rd_status), 32'h0);
        wr('0, 16'h0012);
        check(rd_status == 1'b0 && status == 8'h80, "R11 unknown code ignored",
              {23'b0, rd_status, status}, 32'h80);

        // R1 arm, then abort with a wrong confirm to get back to idle
        wr('0, 16'h00E8);
        check(rd_status == 1'b1 && status == 8'h80, "R1 arm", {23'b0, rd_status, status}, 32'h180);
        wr('0, 16'h0000);
        wr(13'h0020, 16'h1234);
        wait_ready();
        // R6 wrong confirm code discards
        wr('0, 16'h00AA);
        check(rd_status == 1'b0, "R6 wrong confirm to array mode", 32'(rd_status), 32'h0);
        check(buf_active == 1'b0, "R6 window dropped", 32'(buf_active), 32'h0);
        check(status == 8'h80, "R6 no error on wrong confirm", 32'(status), 32'h80);

        // R2 R3 R5 R7 commit of four words mid-window
        buffered_write(32'h0805, 4, 1, 1'b0);
        // R2 count zero, first write on last word of a window (R3 alignment)
        buffered_write(32'h1FFF, 1, 1, 1'b0);
        // R9 write during commit ignored, spread addresses
        buffered_write(32'h0400, 5, 100, 1'b1);

        // R4 out-of-window write
        wr('0, 16'h00E8);
        wr('0, 16'h0001);
        wr(13'h0010, 16'hBEEF);
        wait_ready();
        wr(13'h0900, 16'hDEAD);
        check(status == 8'h90, "R4 out-of-window error", 32'(status), 32'h90);
        wr('0, 16'h00D0);
        check(rd_status == 1'b0 && buf_active == 1'b0, "R6 error forces discard",
              {30'b0, rd_status, buf_active}, 32'h0);
        check(status == 8'h90, "R4 error sticky after abort", 32'(status), 32'h90);

        // R6 valid sequence but sticky error still set
        wr('0, 16'h00E8);
        wr('0, 16'h0000);
        wr(13'h0030, 16'h7777);
        wait_ready();
        wr('0, 16'h00D0);
        check(rd_status == 1'b0 && buf_active == 1'b0, "R6 confirm with old error discards",
              {30'b0, rd_status, buf_active}, 32'h0);

        // R11 clear status
        wr('0, 16'h0050);
        check(status == 8'h80 && rd_status == 1'b0, "R11 0x50 clears error",
              {23'b0, rd_status, status}, 32'h80);

        // R8 write protect
        wp = 1'b1;
        wr('0, 16'h00E8);
        wr('0, 16'h0000);
        wr(13'h0040, 16'h4444);
        check(status == 8'h90, "R8 protected write flags error", 32'(status), 32'h90);
        check(buf_active == 1'b0, "R8 no window under protect", 32'(buf_active), 32'h0);
        wr('0, 16'h00D0);
        check(rd_status == 1'b0, "R8 confirm after protect discards", 32'(rd_status), 32'h0);
        wp = 1'b0;
        wr('0, 16'h0050);
        check(status == 8'h80, "R11 clear after protect", 32'(status), 32'h80);

        // R5 a final clean commit still works after the error paths
        buffered_write(32'h1234, 3, 7, 1'b0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule